// File: doc/BRIEF.md
# Indirect Configuration Register File for a Dual-Channel Disk Interface

This block keeps the per-channel setup of a two-channel disk interface controller. Each channel owns a bank of seven registers: two 16-bit base addresses, a general control byte, a 10-bit read-ahead count with its control bits, and two timing bytes. Software does not address these registers directly. It first writes a byte-wide pointer that selects a bank and a register index. It then reads or writes through one word-wide data port.

The pointer also carries three bus control bits that the block exports unchanged, plus an auto-advance bit. When auto-advance is set, the index moves on after every data-port access, so a whole bank can be loaded by writing the pointer once and then issuing seven data writes. Some fields are write-only and read back as zero. The FIFO-clear command is not stored; it only produces a strobe.

The block exports every field of both banks as flat vectors for the controller logic that uses them.

Top module: `ide_cfg_regfile`

## Requirements
- R1: After reset the pointer reads 0x50. Bank 0 holds command base 0x01F0, control base 0x03F6, general byte 0x01, data timing 0xF5 and command timing 0xDE. Bank 1 holds the same values except command base 0x0170 and control base 0x0376. In both banks the read-ahead count and read-ahead enable are 0.
- R2: Pointer bit 3 selects the bank (0 = bank 0, 1 = bank 1) and pointer bits 2..0 select the index. A data-port write changes only the selected register of the selected bank, and a data-port read returns that register.
- R3: When pointer bit 7 is 1, every data-port read or write advances the index by one, and index 6 (or 7) wraps to 0. When bit 7 is 0, data accesses leave the pointer unchanged.
- R4: Pointer bit 6 drives the posted-write wait-state output, bit 5 drives the burst-disable output and bit 4 drives the medium-select timing output. Bit 5 is write-only and always reads back as 0.
- R5: Index 0 (command base) and index 4 (control base) store and return the full 16-bit data word.
- R6: Index 1 (general byte), index 5 (data timing) and index 6 (command timing) store the low byte of a write. They read with a zero high byte.
- R7: Index 2 and index 3 read as 0. General-byte bit 2 is stored and exported, but it reads back as 0.
- R8: The read-ahead count output is index 3 bits 1..0 above index 2 bits 7..0. The read-ahead enable output is index 3 bit 7.
- R9: A write to index 3 with bit 6 set pulses the bank's FIFO-clear output for exactly the one cycle after the write. The bit is not stored.
- R10: Index 7 reads as 0, and a write to it changes no register.
- R11: When a pointer write and a data access fall in the same cycle, the data access uses the old pointer. The pointer then takes the written value with no auto-advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_i | input | 1 | Pointer write strobe |
| ptr_wdata_i | input | 8 | Pointer write value |
| ptr_rdata_o | output | 8 | Pointer readback (bit 5 reads 0) |
| dat_wr_i | input | 1 | Data-port write strobe |
| dat_rd_i | input | 1 | Data-port read strobe (advances the index) |
| dat_wdata_i | input | 16 | Data-port write value |
| dat_rdata_o | output | 16 | Selected register, combinational |
| posted_ws_o | output | 1 | Posted-write wait state enable |
| burst_dis_o | output | 1 | Master burst disable |
| sel_medium_o | output | 1 | Medium select timing |
| cmd_base_o | output | 32 | Command base per bank, bank b at [16b+15:16b] |
| ctl_base_o | output | 32 | Control base per bank |
| gen_cfg_o | output | 16 | General byte per bank, bank b at [8b+7:8b] |
| ra_count_o | output | 20 | Read-ahead count per bank, bank b at [10b+9:10b] |
| ra_enable_o | output | 2 | Read-ahead enable per bank |
| fifo_clr_o | output | 2 | FIFO-clear pulse per bank |
| data_tim_o | output | 16 | Data timing byte per bank |
| cmd_tim_o | output | 16 | Command timing byte per bank |

## Verification
The bench compares every exported field of both banks, and the pointer readback, against a model on every cycle. A write that lands in the wrong bank or at the wrong index therefore shows up at the ports one cycle after the write. A pointer that advances wrongly stays hidden in the state until the next data access. The bench catches it on the next readback, because that access then returns a different register's value or a write lands in the wrong place. A FIFO-clear strobe that lasts too long, or is stored instead of pulsed, is seen on the second cycle after the write.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
    localparam int CFG_DATA_W  = 16;
    localparam int CFG_BYTE_W  = 8;
    localparam int CFG_IDX_W   = 3;
    localparam int CFG_NUM_REG = 7;
    localparam int CFG_RA_W    = 10;

    // pointer bit positions
    localparam int PTR_AUTOINC = 7;
    localparam int PTR_WAITST  = 6;
    localparam int PTR_BURSTD  = 5;
    localparam int PTR_MEDSEL  = 4;
    localparam int PTR_BANK    = 3;

    // field bit positions
    localparam int GEN_WO_BIT  = 2;
    localparam int RA_EN_BIT   = 7;
    localparam int RA_CLR_BIT  = 6;

    localparam logic [7:0] PTR_RST  = 8'h50;
    localparam logic [7:0] GEN_RST  = 8'h01;
    localparam logic [7:0] DTIM_RST = 8'hF5;
    localparam logic [7:0] CTIM_RST = 8'hDE;
    localparam logic [15:0] CMD_BASE_RST = 16'h01F0;
    localparam logic [15:0] CTL_BASE_RST = 16'h03F6;
    localparam logic [15:0] BANK1_XOR    = 16'h0080;

    typedef enum logic [2:0] {
        IDX_CMD_BASE = 3'd0,
        IDX_GENERAL  = 3'd1,
        IDX_RA_LOW   = 3'd2,
        IDX_RA_CTRL  = 3'd3,
        IDX_CTL_BASE = 3'd4,
        IDX_DAT_TIM  = 3'd5,
        IDX_CMD_TIM  = 3'd6,
        IDX_UNUSED   = 3'd7
    } cfg_idx_e;
endpackage

// File: rtl/ide_cfg_ptr.sv
module ide_cfg_ptr
    import ide_cfg_pkg::*;
#(
    parameter int IDX_W   = CFG_IDX_W,
    parameter int NUM_REG = CFG_NUM_REG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [7:0]       wdata_i,
    input  logic             access_i,
    output logic [7:0]       ptr_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             bank_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REG - 1);

    typedef struct packed {
        logic [7:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [IDX_W-1:0] idx_cur;

    assign idx_cur = st_q.ptr[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.ptr = wdata_i;
        end else if (access_i && st_q.ptr[PTR_AUTOINC]) begin
            if (idx_cur >= LAST_IDX)
                st_d.ptr[IDX_W-1:0] = '0;
            else
                st_d.ptr[IDX_W-1:0] = idx_cur + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ptr <= PTR_RST;
        else        st_q <= st_d;
    end

    assign ptr_o  = st_q.ptr;
    assign idx_o  = idx_cur;
    assign bank_o = st_q.ptr[PTR_BANK];

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && !wr_i && st_q.ptr[PTR_AUTOINC] && idx_cur == LAST_IDX) |=> (idx_o == '0));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && !wr_i && !st_q.ptr[PTR_AUTOINC]) |=> $stable(ptr_o));
    assert_ptr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ptr_o == $past(wdata_i)));
endmodule

// File: rtl/ide_cfg_bank.sv
module ide_cfg_bank
    import ide_cfg_pkg::*;
#(
    parameter int          DATA_W  = CFG_DATA_W,
    parameter int          IDX_W   = CFG_IDX_W,
    parameter int          RA_W    = CFG_RA_W,
    parameter logic [15:0] CMD_RST = CMD_BASE_RST,
    parameter logic [15:0] CTL_RST = CTL_BASE_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] cmd_base_o,
    output logic [DATA_W-1:0] ctl_base_o,
    output logic [7:0]        gen_o,
    output logic [RA_W-1:0]   ra_count_o,
    output logic              ra_en_o,
    output logic              fifo_clr_o,
    output logic [7:0]        dtim_o,
    output logic [7:0]        ctim_o
);
    localparam int HI_W = RA_W - 8;

    typedef struct packed {
        logic [DATA_W-1:0] cmd_base;
        logic [DATA_W-1:0] ctl_base;
        logic [7:0]        gen;
        logic [RA_W-1:0]   ra_cnt;
        logic              ra_en;
        logic              fifo_clr;
        logic [7:0]        dtim;
        logic [7:0]        ctim;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.fifo_clr = 1'b0;
        if (wr_en_i) begin
            case (idx_i)
                IDX_CMD_BASE: st_d.cmd_base = wdata_i;
                IDX_GENERAL:  st_d.gen = wdata_i[7:0];
                IDX_RA_LOW:   st_d.ra_cnt[7:0] = wdata_i[7:0];
                IDX_RA_CTRL: begin
                    st_d.ra_cnt[RA_W-1:8] = wdata_i[HI_W-1:0];
                    st_d.ra_en    = wdata_i[RA_EN_BIT];
                    st_d.fifo_clr = wdata_i[RA_CLR_BIT];
                end
                IDX_CTL_BASE: st_d.ctl_base = wdata_i;
                IDX_DAT_TIM:  st_d.dtim = wdata_i[7:0];
                IDX_CMD_TIM:  st_d.ctim = wdata_i[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (idx_i)
            IDX_CMD_BASE: rdata_o = st_q.cmd_base;
            IDX_GENERAL: begin
                rdata_o[7:0] = st_q.gen;
                rdata_o[GEN_WO_BIT] = 1'b0;
            end
            IDX_CTL_BASE: rdata_o[DATA_W-1:0] = st_q.ctl_base;
            IDX_DAT_TIM:  rdata_o[7:0] = st_q.dtim;
            IDX_CMD_TIM:  rdata_o[7:0] = st_q.ctim;
            default:      rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmd_base <= CMD_RST;
            st_q.ctl_base <= CTL_RST;
            st_q.gen      <= GEN_RST;
            st_q.ra_cnt   <= '0;
            st_q.ra_en    <= 1'b0;
            st_q.fifo_clr <= 1'b0;
            st_q.dtim     <= DTIM_RST;
            st_q.ctim     <= CTIM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_base_o = st_q.cmd_base;
    assign ctl_base_o = st_q.ctl_base;
    assign gen_o      = st_q.gen;
    assign ra_count_o = st_q.ra_cnt;
    assign ra_en_o    = st_q.ra_en;
    assign fifo_clr_o = st_q.fifo_clr;
    assign dtim_o     = st_q.dtim;
    assign ctim_o     = st_q.ctim;

    assert_fifo_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr_o |-> $past(wr_en_i && idx_i == IDX_RA_CTRL && wdata_i[RA_CLR_BIT]));
    assert_idx7_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && idx_i == IDX_UNUSED) |=> ($stable(cmd_base_o) && $stable(ctl_base_o)
            && $stable(gen_o) && $stable(ra_count_o) && $stable(ra_en_o)
            && $stable(dtim_o) && $stable(ctim_o)));
    assert_no_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(cmd_base_o) && $stable(gen_o) && $stable(ctim_o)));
endmodule

// File: rtl/ide_cfg_regfile.sv
module ide_cfg_regfile
    import ide_cfg_pkg::*;
#(
    parameter int DATA_W  = CFG_DATA_W,
    parameter int IDX_W   = CFG_IDX_W,
    parameter int NUM_REG = CFG_NUM_REG,
    parameter int RA_W    = CFG_RA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_wr_i,
    input  logic [7:0]          ptr_wdata_i,
    output logic [7:0]          ptr_rdata_o,
    input  logic                dat_wr_i,
    input  logic                dat_rd_i,
    input  logic [DATA_W-1:0]   dat_wdata_i,
    output logic [DATA_W-1:0]   dat_rdata_o,
    output logic                posted_ws_o,
    output logic                burst_dis_o,
    output logic                sel_medium_o,
    output logic [2*DATA_W-1:0] cmd_base_o,
    output logic [2*DATA_W-1:0] ctl_base_o,
    output logic [15:0]         gen_cfg_o,
    output logic [2*RA_W-1:0]   ra_count_o,
    output logic [1:0]          ra_enable_o,
    output logic [1:0]          fifo_clr_o,
    output logic [15:0]         data_tim_o,
    output logic [15:0]         cmd_tim_o
);
    localparam int NUM_BANKS = 2;

    logic [7:0]       ptr_q;
    logic [IDX_W-1:0] idx;
    logic             bank_sel;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    ide_cfg_ptr #(.IDX_W(IDX_W), .NUM_REG(NUM_REG)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ptr_wr_i),
        .wdata_i (ptr_wdata_i),
        .access_i(dat_wr_i | dat_rd_i),
        .ptr_o   (ptr_q),
        .idx_o   (idx),
        .bank_o  (bank_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_en;
        assign wr_en = dat_wr_i && (bank_sel == 1'(b));
        ide_cfg_bank #(
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W),
            .RA_W   (RA_W),
            .CMD_RST(b == 0 ? CMD_BASE_RST : (CMD_BASE_RST ^ BANK1_XOR)),
            .CTL_RST(b == 0 ? CTL_BASE_RST : (CTL_BASE_RST ^ BANK1_XOR))
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en),
            .idx_i     (idx),
            .wdata_i   (dat_wdata_i),
            .rdata_o   (bank_rd[b]),
            .cmd_base_o(cmd_base_o[b*DATA_W +: DATA_W]),
            .ctl_base_o(ctl_base_o[b*DATA_W +: DATA_W]),
            .gen_o     (gen_cfg_o[b*8 +: 8]),
            .ra_count_o(ra_count_o[b*RA_W +: RA_W]),
            .ra_en_o   (ra_enable_o[b]),
            .fifo_clr_o(fifo_clr_o[b]),
            .dtim_o    (data_tim_o[b*8 +: 8]),
            .ctim_o    (cmd_tim_o[b*8 +: 8])
        );
    end

    always_comb begin
        ptr_rdata_o = ptr_q;
        ptr_rdata_o[PTR_BURSTD] = 1'b0;
    end

    assign dat_rdata_o  = bank_rd[bank_sel];
    assign posted_ws_o  = ptr_q[PTR_WAITST];
    assign burst_dis_o  = ptr_q[PTR_BURSTD];
    assign sel_medium_o = ptr_q[PTR_MEDSEL];

    assert_wo_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_RA_LOW || idx == IDX_RA_CTRL) |-> (dat_rdata_o == '0));
    assert_unused_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_UNUSED) |-> (dat_rdata_o == '0));
    assert_bit5_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_dis_o |-> !ptr_rdata_o[PTR_BURSTD]);
endmodule

// File: tb/sim_ide_cfg_regfile.sv
module sim_ide_cfg_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ptr_wr;
    logic [7:0]  ptr_wdata;
    logic [7:0]  ptr_rdata;
    logic        dat_wr, dat_rd;
    logic [15:0] dat_wdata, dat_rdata;
    logic        posted_ws, burst_dis, sel_medium;
    logic [31:0] cmd_base, ctl_base;
    logic [15:0] gen_cfg, data_tim, cmd_tim;
    logic [19:0] ra_count;
    logic [1:0]  ra_enable, fifo_clr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ide_cfg_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wdata), .ptr_rdata_o(ptr_rdata),
        .dat_wr_i(dat_wr), .dat_rd_i(dat_rd), .dat_wdata_i(dat_wdata), .dat_rdata_o(dat_rdata),
        .posted_ws_o(posted_ws), .burst_dis_o(burst_dis), .sel_medium_o(sel_medium),
        .cmd_base_o(cmd_base), .ctl_base_o(ctl_base), .gen_cfg_o(gen_cfg),
        .ra_count_o(ra_count), .ra_enable_o(ra_enable), .fifo_clr_o(fifo_clr),
        .data_tim_o(data_tim), .cmd_tim_o(cmd_tim)
    );

    // model
    logic [7:0]  m_ptr;
    logic [15:0] m_cmd [2];
    logic [15:0] m_ctl [2];
    logic [7:0]  m_gen [2];
    logic [7:0]  m_dt  [2];
    logic [7:0]  m_ct  [2];
    logic [9:0]  m_ra  [2];
    logic        m_raen [2];
    logic        m_fifo [2];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = 8'h50;
        m_cmd[0] = 16'h01F0; m_cmd[1] = 16'h0170;
        m_ctl[0] = 16'h03F6; m_ctl[1] = 16'h0376;
        for (int b = 0; b < 2; b++) begin
            m_gen[b] = 8'h01; m_dt[b] = 8'hF5; m_ct[b] = 8'hDE;
            m_ra[b] = '0; m_raen[b] = 1'b0; m_fifo[b] = 1'b0;
        end
    endtask

    function automatic logic [15:0] exp_rd();
        int b = int'(m_ptr[3]);
        case (m_ptr[2:0])
            3'd0: return m_cmd[b];
            3'd1: return {8'h00, m_gen[b] & 8'hFB};
            3'd4: return m_ctl[b];
            3'd5: return {8'h00, m_dt[b]};
            3'd6: return {8'h00, m_ct[b]};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_write(input logic [15:0] v);
        int b = int'(m_ptr[3]);
        case (m_ptr[2:0])
            3'd0: m_cmd[b] = v;
            3'd1: m_gen[b] = v[7:0];
            3'd2: m_ra[b][7:0] = v[7:0];
            3'd3: begin m_ra[b][9:8] = v[1:0]; m_raen[b] = v[7]; m_fifo[b] = v[6]; end
            3'd4: m_ctl[b] = v;
            3'd5: m_dt[b] = v[7:0];
            3'd6: m_ct[b] = v[7:0];
            default: ;
        endcase
    endtask

    task automatic model_inc();
        if (m_ptr[7]) m_ptr[2:0] = (m_ptr[2:0] >= 3'd6) ? 3'd0 : m_ptr[2:0] + 3'd1;
    endtask

    task automatic check_outs(input string tag);
        chk({tag, " R4 ptr readback"}, 32'(ptr_rdata), 32'(m_ptr & 8'hDF));
        chk({tag, " R4 pin bits"}, {29'd0, posted_ws, burst_dis, sel_medium},
            {29'd0, m_ptr[6], m_ptr[5], m_ptr[4]});
        for (int b = 0; b < 2; b++) begin
            chk({tag, " R5 cmd base"}, 32'(cmd_base[b*16 +: 16]), 32'(m_cmd[b]));
            chk({tag, " R5 ctl base"}, 32'(ctl_base[b*16 +: 16]), 32'(m_ctl[b]));
            chk({tag, " R6 general"}, 32'(gen_cfg[b*8 +: 8]), 32'(m_gen[b]));
            chk({tag, " R6 timings"}, {16'd0, data_tim[b*8 +: 8], cmd_tim[b*8 +: 8]},
                {16'd0, m_dt[b], m_ct[b]});
            chk({tag, " R8 ra count/en"}, {21'd0, ra_enable[b], ra_count[b*10 +: 10]},
                {21'd0, m_raen[b], m_ra[b]});
            chk({tag, " R9 fifo pulse"}, 32'(fifo_clr[b]), 32'(m_fifo[b]));
        end
    endtask

    // one cycle: wp/wr/rd strobes
    task automatic cycle(input string tag, input bit wp, input logic [7:0] pv,
                         input bit wr, input bit rd, input logic [15:0] wv);
        @(negedge clk);
        check_outs(tag);
        m_fifo[0] = 1'b0; m_fifo[1] = 1'b0;
        ptr_wr = wp; ptr_wdata = pv;
        dat_wr = wr; dat_rd = rd; dat_wdata = wv;
        #1;
        if (wr || rd) chk({tag, " R2 data read"}, 32'(dat_rdata), 32'(exp_rd()));
        @(posedge clk);
        if (wr) model_write(wv);
        if (wp) m_ptr = pv;
        else if (wr || rd) model_inc();
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; ptr_wr = 0; ptr_wdata = 0; dat_wr = 0; dat_rd = 0; dat_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cycle("R1 reset", 0, 0, 0, 0, 0);
        cycle("R1 reset", 0, 0, 0, 1, 0);
        // R3: auto-advance through bank 1 and wrap, reading every register
        cycle("R3", 1, 8'h88, 0, 0, 0);
        for (int i = 0; i < 9; i++) cycle("R3 walk", 0, 0, 0, 1, 0);
        // R3 hold with bit 7 clear; R5 full word writes
        cycle("R3", 1, 8'h04, 0, 0, 0);
        cycle("R5", 0, 0, 1, 0, 16'hBEEF);
        cycle("R5", 0, 0, 0, 1, 0);
        // R6 high byte dropped; R7 bit 2 hidden
        cycle("R6", 1, 8'h01, 0, 0, 0);
        cycle("R6", 0, 0, 1, 0, 16'hA5FF);
        cycle("R7", 0, 0, 0, 1, 0);
        // R8/R9 read-ahead with fifo clear, then R7 reads zero
        cycle("R8", 1, 8'h02, 1, 0, 16'h0000);
        cycle("R8", 0, 0, 1, 0, 16'h12AB);
        cycle("R9", 1, 8'h03, 0, 0, 0);
        cycle("R9", 0, 0, 1, 0, 16'h00C2);
        cycle("R9", 0, 0, 0, 0, 0);
        cycle("R7", 0, 0, 0, 1, 0);
        // R10 index 7
        cycle("R10", 1, 8'h0F, 0, 0, 0);
        cycle("R10", 0, 0, 1, 0, 16'hFFFF);
        cycle("R10", 0, 0, 0, 1, 0);
        // R11 pointer write with data access same cycle
        cycle("R11", 1, 8'h80, 0, 0, 0);
        cycle("R11", 1, 8'hB5, 1, 0, 16'h4321);
        cycle("R11", 0, 0, 0, 1, 0);
        cycle("R4", 1, 8'h20, 0, 0, 0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 5);
            logic [7:0]  pv = 8'($urandom);
            logic [15:0] wv = 16'($urandom);
            case (r)
                0: cycle("R2 rnd", 1, pv, 0, 0, 0);
                1, 2: cycle("R2 rnd", 0, 0, 1, 0, wv);
                3: cycle("R3 rnd", 0, 0, 0, 1, 0);
                default: cycle("R11 rnd", 1, pv, 1, 0, wv);
            endcase
        end
        cycle("end", 0, 0, 0, 0, 0);
        cycle("end", 0, 0, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule